// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block turns a group of raw interrupt request lines into a registered set of pending-request bits. Each line has its own trigger-mode bit. In edge mode a line records a request when its input goes from low to high, and the request stays pending until it is acknowledged. In level mode the pending bit follows the input level, and an acknowledge does not clear it.

A consumer elsewhere in the chip, such as a priority resolver, reads the pending vector and acknowledges one line by its binary index. Software-visible decode writes whole bytes into the trigger-mode register. A fixed per-instance writable-bit mask forces some lines to stay edge-triggered. A 16-line arrangement uses two instances. Bit 3 of a global line number selects the instance, and the low three bits select the line within it. The two instances usually carry masks of 0xF8 and 0xDE.

Top module: `irl_latch`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the pending vector and the trigger-mode register are zero. Every line is in edge mode (mode bit 0 = edge, 1 = level).
- R2: In edge mode, a pending bit is set one cycle after the input is sampled high, when the input was sampled low on the previous clock (or no sample has been taken since reset). A line that stays low never becomes pending.
- R3: In edge mode, a low input does not clear a pending bit. An input held high does not set the bit again once it has been cleared.
- R4: In level mode, the pending bit equals the input level sampled on the previous clock.
- R5: An acknowledge (ack_vld high, ack_idx the binary line number) clears the pending bit of that edge-mode line on the next cycle. It leaves every other line unchanged.
- R6: An acknowledge addressed to a level-mode line whose input is high has no effect on the pending vector.
- R7: When an edge-mode line has a rising edge in the same cycle that it is acknowledged, the line is pending afterwards.
- R8: A mode write stores mode_wdata AND WMASK. Bits outside WMASK always read 0. The default WMASK is 0xF8, and the second-controller value is 0xDE.
- R9: A mode write takes effect on the next cycle. A line switched from level to edge keeps its pending bit until it is acknowledged. A line switched from edge to level then follows its input.
- R10: Without a write strobe the trigger-mode register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | LINES | Raw request levels, sampled each clock |
| ack_vld | input | 1 | Acknowledge strobe |
| ack_idx | input | IDX_W | Binary index of the acknowledged line |
| mode_wr | input | 1 | Trigger-mode register write strobe |
| mode_wdata | input | LINES | Trigger-mode write data |
| irr_q | output | LINES | Pending-request vector |
| mode_q | output | LINES | Trigger-mode register (masked stored value) |

## Verification
The bench targets these cases:
- **Acknowledge while the input is still high.** A latch that re-armed on level would raise the request again at once.
- **Acknowledge on the same cycle as a new rising edge.** An ordering mistake would lose that fresh request.
- **Acknowledge on a level line.** A design that cleared it would drop a still-active request.
- **Switching the trigger mode while requests are pending.** A level-to-edge switch that wrongly cleared the pending bit would be caught here.
- **Full-ones mode writes to two instances with different masks.** A missing mask would let forced-edge lines turn level.

// File: rtl/irl_pkg.sv
package irl_pkg;

   typedef enum logic {
      TRIG_EDGE  = 1'b0,
      TRIG_LEVEL = 1'b1
   } trig_e;

   typedef struct packed {
      logic pend;
      logic last;
   } line_state_t;

   function automatic line_state_t irl_line_next(
      input trig_e       trig,
      input logic        lvl,
      input logic        ack_hit,
      input line_state_t cur
   );
      line_state_t nx;
      nx.last = lvl;
      if (trig == TRIG_LEVEL) begin
         nx.pend = lvl;
      end else begin
         nx.pend = (cur.pend & ~ack_hit) | (lvl & ~cur.last);
      end
      return nx;
   endfunction

endpackage

// File: rtl/irl_ack_dec.sv
module irl_ack_dec #(
   parameter int LINES = 8,
   parameter int IDX_W = 3
) (
   input  logic             vld,
   input  logic [IDX_W-1:0] idx,
   output logic [LINES-1:0] hit
);

   for (genvar g = 0; g < LINES; g++) begin : g_hit
      assign hit[g] = vld && (idx == IDX_W'(g));
   end

endmodule

// File: rtl/irl_mode_reg.sv
module irl_mode_reg #(
   parameter int               LINES = 8,
   parameter logic [LINES-1:0] WMASK = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [LINES-1:0] wdata,
   output logic [LINES-1:0] mode
);

   for (genvar g = 0; g < LINES; g++) begin : g_bit
      if (WMASK[g]) begin : g_rw
         logic bit_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               bit_q <= 1'b0;
            end else if (wr) begin
               bit_q <= wdata[g];
            end
         end
         assign mode[g] = bit_q;
      end else begin : g_fixed
         assign mode[g] = 1'b0;
      end
   end

endmodule

// File: rtl/irl_line_cell.sv
module irl_line_cell
   import irl_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic level_mode,
   input  logic ack_hit,
   output logic pend
);

   line_state_t st_q;
   line_state_t st_d;
   trig_e       trig;

   assign trig = level_mode ? TRIG_LEVEL : TRIG_EDGE;

   always_comb begin
      st_d = irl_line_next(trig, lvl, ack_hit, st_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= '0;
      end else begin
         st_q <= st_d;
      end
   end

   assign pend = st_q.pend;

endmodule

// File: rtl/irl_latch.sv
module irl_latch #(
   parameter int               LINES = 8,
   parameter logic [LINES-1:0] WMASK = 8'hF8,
   parameter int               IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] req_in,
   input  logic             ack_vld,
   input  logic [IDX_W-1:0] ack_idx,
   input  logic             mode_wr,
   input  logic [LINES-1:0] mode_wdata,
   output logic [LINES-1:0] irr_q,
   output logic [LINES-1:0] mode_q
);

   localparam int IDX_SPAN = 1 << IDX_W;

   if (LINES < 1) begin : g_bad_lines
      $error("irl_latch: LINES must be at least 1");
   end
   if (IDX_SPAN < LINES) begin : g_bad_idx
      $error("irl_latch: IDX_W too narrow for LINES");
   end

   logic [LINES-1:0] ack_hit;

   irl_ack_dec #(.LINES(LINES), .IDX_W(IDX_W)) u_ack_dec (
      .vld (ack_vld),
      .idx (ack_idx),
      .hit (ack_hit)
   );

   irl_mode_reg #(.LINES(LINES), .WMASK(WMASK)) u_mode_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (mode_wr),
      .wdata (mode_wdata),
      .mode  (mode_q)
   );

   for (genvar g = 0; g < LINES; g++) begin : g_line
      irl_line_cell u_cell (
         .clk        (clk),
         .rst_n      (rst_n),
         .lvl        (req_in[g]),
         .level_mode (mode_q[g]),
         .ack_hit    (ack_hit[g]),
         .pend       (irr_q[g])
      );
   end

endmodule

// File: rtl/irl_latch_chk.sv
module irl_latch_chk #(
   parameter int               LINES = 8,
   parameter int               IDX_W = 3,
   parameter logic [LINES-1:0] WMASK = '1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [LINES-1:0] req_in,
   input logic             ack_vld,
   input logic [IDX_W-1:0] ack_idx,
   input logic             mode_wr,
   input logic [LINES-1:0] mode_wdata,
   input logic [LINES-1:0] irr_q,
   input logic [LINES-1:0] mode_q
);

   a_r8_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q & ~WMASK) == '0);

   a_r9_write: assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr |=> mode_q == $past(mode_wdata & WMASK));

   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_wr |=> $stable(mode_q));

   for (genvar g = 0; g < LINES; g++) begin : g_ln
      a_r4_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
         mode_q[g] |=> irr_q[g] == $past(req_in[g]));

      a_r3_edge_keep: assert property (@(posedge clk) disable iff (!rst_n)
         (!mode_q[g] && irr_q[g] && !(ack_vld && ack_idx == IDX_W'(g)))
         |=> irr_q[g]);

      a_r5_ack_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (!mode_q[g] && ack_vld && ack_idx == IDX_W'(g) && !req_in[g])
         |=> !irr_q[g]);

      a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
         (!mode_q[g] && !irr_q[g] && !req_in[g]) |=> !irr_q[g]);
   end

endmodule

bind irl_latch irl_latch_chk #(.LINES(LINES), .IDX_W(IDX_W), .WMASK(WMASK)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_in     (req_in),
   .ack_vld    (ack_vld),
   .ack_idx    (ack_idx),
   .mode_wr    (mode_wr),
   .mode_wdata (mode_wdata),
   .irr_q      (irr_q),
   .mode_q     (mode_q)
);

// File: tb/irl_latch_bench.sv
module irl_latch_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] req_in = '0;
   logic       ack_vld = 1'b0;
   logic [2:0] ack_idx = '0;
   logic       mode_wr = 1'b0;
   logic [7:0] mode_wdata = '0;
   logic [7:0] irr_a, mode_a, irr_b, mode_b;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   irl_latch #(.LINES(8), .WMASK(8'hF8)) u_irl_latch (
      .clk(clk), .rst_n(rst_n), .req_in(req_in), .ack_vld(ack_vld),
      .ack_idx(ack_idx), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
      .irr_q(irr_a), .mode_q(mode_a)
   );

   irl_latch #(.LINES(8), .WMASK(8'hDE)) u_irl_latch_b (
      .clk(clk), .rst_n(rst_n), .req_in(req_in), .ack_vld(ack_vld),
      .ack_idx(ack_idx), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
      .irr_q(irr_b), .mode_q(mode_b)
   );

   typedef struct {
      logic [7:0] irr_a;
      logic [7:0] mode_a;
      logic [7:0] irr_b;
      logic [7:0] mode_b;
      string      tag;
   } exp_t;

   exp_t exp_q[$];

   logic [7:0] m_irr  [2];
   logic [7:0] m_last [2];
   logic [7:0] m_mode [2];
   logic [7:0] m_mask [2];

   task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
      end
   endtask

   task automatic step(string tag, logic [7:0] req, logic av, logic [2:0] ai,
                       logic wr, logic [7:0] wd);
      exp_t e;
      @(negedge clk);
      req_in = req; ack_vld = av; ack_idx = ai; mode_wr = wr; mode_wdata = wd;
      for (int c = 0; c < 2; c++) begin
         logic [7:0] nirr;
         for (int i = 0; i < 8; i++) begin
            if (m_mode[c][i])
               nirr[i] = req[i];
            else
               nirr[i] = (m_irr[c][i] & ~(av && ai == 3'(i))) | (req[i] & ~m_last[c][i]);
         end
         m_irr[c]  = nirr;
         m_last[c] = req;
         if (wr) m_mode[c] = wd & m_mask[c];
      end
      e.irr_a = m_irr[0]; e.mode_a = m_mode[0];
      e.irr_b = m_irr[1]; e.mode_b = m_mode[1];
      e.tag = tag;
      exp_q.push_back(e);
   endtask

   initial begin : monitor
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.tag, "irr_a", irr_a, e.irr_a);
            check(e.tag, "mode_a", mode_a, e.mode_a);
            check(e.tag, "irr_b", irr_b, e.irr_b);
            check(e.tag, "mode_b", mode_b, e.mode_b);
         end
      end
   end

   initial begin : watchdog
      #2000000;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : driver
      logic [7:0] lfsr;
      m_mask[0] = 8'hF8; m_mask[1] = 8'hDE;
      for (int c = 0; c < 2; c++) begin
         m_irr[c] = '0; m_last[c] = '0; m_mode[c] = '0;
      end
      req_in = 8'hFF;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: zero state during reset
      check("R1", "irr_a", irr_a, 8'h00);
      check("R1", "mode_b", mode_b, 8'h00);
      req_in = 8'h00;
      rst_n = 1'b1;
      // R2: rising edges on lines 0 and 3
      step("R2", 8'h09, 0, 0, 0, 0);
      // R3: held high, no change
      step("R3", 8'h09, 0, 0, 0, 0);
      // R5: ack line 0 while still high clears only line 0
      step("R5", 8'h09, 1, 0, 0, 0);
      // R3: held high does not re-set
      step("R3", 8'h09, 0, 0, 0, 0);
      // R3: low input keeps pending line 3
      step("R3", 8'h00, 0, 0, 0, 0);
      // R2: new rise on line 0
      step("R2", 8'h01, 0, 0, 0, 0);
      step("R3", 8'h00, 0, 0, 0, 0);
      // R7: rising edge and ack on same line
      step("R7", 8'h01, 1, 0, 0, 0);
      // R5: ack line 3
      step("R5", 8'h01, 1, 3, 0, 0);
      // R8: full-ones write masked per instance
      step("R8", 8'h00, 0, 0, 1, 8'hFF);
      // R4: level lines follow input
      step("R4", 8'hA0, 0, 0, 0, 0);
      step("R4", 8'h28, 0, 0, 0, 0);
      // R6: ack a level line held high
      step("R6", 8'h28, 1, 5, 0, 0);
      step("R6", 8'h28, 1, 3, 0, 0);
      // R9: level to edge keeps pending bits
      step("R9", 8'h28, 0, 0, 1, 8'h00);
      step("R9", 8'h00, 0, 0, 0, 0);
      step("R9", 8'h00, 1, 5, 0, 0);
      // R9: edge to level then follows
      step("R9", 8'h10, 0, 0, 1, 8'h30);
      step("R9", 8'h00, 0, 0, 0, 0);
      step("R9", 8'h30, 0, 0, 0, 0);
      // R10: mixed traffic without writes, plus occasional writes
      lfsr = 8'h5A;
      for (int n = 0; n < 60; n++) begin
         logic [7:0] r;
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         r = lfsr;
         step((n % 9 == 4) ? "R8" : "R10", r, lfsr[2], lfsr[6:4],
              (n % 9 == 4), ~lfsr);
      end
      step("R10", 8'h00, 0, 0, 0, 0);
      repeat (3) @(posedge clk);
      #3;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule